// File: doc/BRIEF.md
# Single-Channel Memory-to-Peripheral Block Transfer Engine

This block moves a block of bytes from memory to an I/O peripheral over a bus it shares with the CPU. Software first loads a start address and a byte count. A peripheral then asks for service by raising its request line. The engine asks the CPU for the bus with a hold request and waits for the hold acknowledge. It then tells the peripheral, through an acknowledge line, that the transfer is starting, and runs one read-then-write strobe pair per byte. It steps the address up and the count down after each byte.

The bus is handed back when the count runs out. A one-cycle terminal-count pulse marks the end of the block. The address bus and both strobes are enabled only while the CPU's hold acknowledge is high. Outside those times the address output reads as zero and both strobes stay inactive (high).

Top module: `dma_xfer_ctrl`

## Requirements
- R1: During and right after a synchronous reset, `hold_req`, `periph_ack`, `xfer_done` and `bus_oe` are 0, `mem_rd_n` and `io_wr_n` are 1, and the loaded count is zero.
- R2: A `periph_req` seen at a clock edge while idle with a nonzero count raises `hold_req` after that edge. `hold_req` then stays high until the last byte of the block has been written.
- R3: The engine waits in the hold state for as long as `hold_ack` is low. `periph_ack` rises one cycle after `hold_ack` is seen high, stays high through the whole transfer, and falls in the same cycle as `hold_req`.
- R4: Each byte takes the following cycles, in order:
  - one cycle with only `mem_rd_n` low;
  - one cycle with both `mem_rd_n` and `io_wr_n` low;
  - between two bytes, one cycle with both strobes high.
  `io_wr_n` is never low while `mem_rd_n` is high.
- R5: The address driven during byte k (k = 0, 1, ...) equals the loaded start address plus k, modulo 2^AW.
- R6: A loaded count of N (1 to 2^CW-1) produces exactly N write strobes, after which the internal count is zero.
- R7: `xfer_done` is high for exactly one cycle: the cycle after the last write strobe, the same cycle in which `hold_req` and `periph_ack` are low again.
- R8: A `periph_req` while the count is zero, including after a finished block and before any reload, leaves `hold_req` low.
- R9: `bus_oe` is high only while the engine owns the bus (from the acknowledge cycle to the end of the last byte) and `hold_ack` is high. The strobes are low only when `bus_oe` is high, and `bus_addr` reads 0 whenever `bus_oe` is low.
- R10: A `cfg_load` pulse while a transfer is in progress (`hold_req` high) is ignored. The running block keeps its addresses and its byte count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Load start address and count (accepted only while idle) |
| cfg_addr | input | AW | Start address to load |
| cfg_count | input | CW | Byte count to load |
| periph_req | input | 1 | Peripheral service request |
| periph_ack | output | 1 | Acknowledge to peripheral: transfer in progress |
| hold_req | output | 1 | Bus hold request to the CPU |
| hold_ack | input | 1 | Hold acknowledge from the CPU |
| bus_addr | output | AW | Memory address for the current byte |
| bus_oe | output | 1 | Output enable for address and strobe drivers |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| io_wr_n | output | 1 | Peripheral write strobe, active low |
| xfer_done | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench builds the engine with an 8-bit address and a 4-bit count. A block that starts just below the top of the address space therefore crosses the wrap point from all-ones to zero. The largest legal count, 15, is also short enough to run in full, and the single-byte block exercises the case where the first byte is also the last. The bench varies the delay before the hold acknowledge and issues a reload in the middle of a block. It also raises requests while the count is zero. Every output is compared against a behavioural model on each cycle.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_HOLD  = 3'd1,
        PH_GRANT = 3'd2,
        PH_READ  = 3'd3,
        PH_WRITE = 3'd4,
        PH_GAP   = 3'd5
    } phase_e;

    typedef struct packed {
        logic hold;   // bus requested from CPU
        logic ack;    // peripheral told transfer is running
        logic owns;   // engine may drive the bus
        logic rd;     // memory read phase
        logic wr;     // peripheral write phase
    } ctl_t;

    function automatic ctl_t decode_phase(phase_e p);
        ctl_t c;
        c.hold = (p != PH_IDLE);
        c.ack  = (p == PH_GRANT) || (p == PH_READ) || (p == PH_WRITE) || (p == PH_GAP);
        c.owns = c.ack;
        c.rd   = (p == PH_READ) || (p == PH_WRITE);
        c.wr   = (p == PH_WRITE);
        return c;
    endfunction

endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          busy,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic          cnt_zero,
    output logic          last_byte
);
    localparam logic [AW-1:0] ADDR_INC = AW'(1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            cnt_q    <= '0;
        end else if (cfg_load && !busy) begin
            cur_addr <= cfg_addr;
            cnt_q    <= cfg_count;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_INC;
            cnt_q    <= cnt_q - CNT_ONE;
        end
    end

    assign cnt_zero  = (cnt_q == '0);
    assign last_byte = (cnt_q == CNT_ONE);

    // R6: every completed byte takes exactly one off the count
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        step |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    // R10: a load request during a transfer leaves the address alone
    a_r10_load_blocked: assert property (@(posedge clk) disable iff (rst)
        (busy && !step && cfg_load) |=> $stable(cur_addr));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic periph_req,
    input  logic hold_ack,
    input  logic cnt_zero,
    input  logic last_byte,
    output ctl_t ctl,
    output logic step,
    output logic busy,
    output logic tc_pulse
);
    phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            tc_pulse <= 1'b0;
        end else begin
            tc_pulse <= 1'b0;
            unique case (ph_q)
                PH_IDLE:  if (periph_req && !cnt_zero) ph_q <= PH_HOLD;
                PH_HOLD:  if (hold_ack) ph_q <= PH_GRANT;
                PH_GRANT: ph_q <= PH_READ;
                PH_READ:  ph_q <= PH_WRITE;
                PH_WRITE: begin
                    if (last_byte) begin
                        ph_q     <= PH_IDLE;
                        tc_pulse <= 1'b1;
                    end else begin
                        ph_q <= PH_GAP;
                    end
                end
                PH_GAP:   ph_q <= PH_READ;
                default:  ph_q <= PH_IDLE;
            endcase
        end
    end

    assign ctl  = decode_phase(ph_q);
    assign step = (ph_q == PH_WRITE);
    assign busy = (ph_q != PH_IDLE);

    // R4: a read-only cycle is always followed by the write cycle
    a_r4_read_then_write: assert property (@(posedge clk) disable iff (rst)
        (ctl.rd && !ctl.wr) |=> ctl.wr);

    // R2: the hold request only ends together with the terminal count
    a_r2_hold_until_done: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.hold) |-> tc_pulse);

    // R7: terminal count follows a byte completion and lasts one cycle
    a_r7_tc_after_step: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> ($past(step) && !ctl.hold));
    a_r7_tc_single: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !tc_pulse);

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dma_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          hold_req,
    input  logic          hold_ack,
    output logic [AW-1:0] bus_addr,
    output logic          bus_oe,
    output logic          mem_rd_n,
    output logic          io_wr_n,
    output logic          xfer_done
);
    ctl_t          ctl;
    logic          step, busy, cnt_zero, last_byte;
    logic [AW-1:0] cur_addr;

    dma_xfer_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .cfg_addr  (cfg_addr),
        .cfg_count (cfg_count),
        .busy      (busy),
        .step      (step),
        .cur_addr  (cur_addr),
        .cnt_zero  (cnt_zero),
        .last_byte (last_byte)
    );

    dma_xfer_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .periph_req (periph_req),
        .hold_ack   (hold_ack),
        .cnt_zero   (cnt_zero),
        .last_byte  (last_byte),
        .ctl        (ctl),
        .step       (step),
        .busy       (busy),
        .tc_pulse   (xfer_done)
    );

    assign hold_req   = ctl.hold;
    assign periph_ack = ctl.ack;
    assign bus_oe     = ctl.owns && hold_ack;
    assign bus_addr   = bus_oe ? cur_addr : '0;
    assign mem_rd_n   = !(ctl.rd && bus_oe);
    assign io_wr_n    = !(ctl.wr && bus_oe);

    // R8: no hold request can start from a zero count
    a_r8_zero_count_ignored: assert property (@(posedge clk) disable iff (rst)
        (!hold_req && cnt_zero) |=> !hold_req);

    // R9: strobes only while the drivers are enabled
    a_r9_strobe_needs_oe: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n || !io_wr_n) |-> bus_oe);

    // R4: the write strobe never appears without the read strobe
    a_r4_write_implies_read: assert property (@(posedge clk) disable iff (rst)
        !io_wr_n |-> !mem_rd_n);

    // R3: acknowledge to the peripheral only inside a hold
    a_r3_ack_within_hold: assert property (@(posedge clk) disable iff (rst)
        periph_ack |-> hold_req);

endmodule

// File: tb/dma_xfer_ctrl_tb.sv
module dma_xfer_ctrl_tb;
    localparam int AW = 8;
    localparam int CW = 4;
    localparam int AMOD = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          periph_req = 1'b0;
    logic          hold_ack = 1'b0;
    logic          periph_ack, hold_req, bus_oe, mem_rd_n, io_wr_n, xfer_done;
    logic [AW-1:0] bus_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_xfer_ctrl #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .periph_req(periph_req), .periph_ack(periph_ack),
        .hold_req(hold_req), .hold_ack(hold_ack), .bus_addr(bus_addr),
        .bus_oe(bus_oe), .mem_rd_n(mem_rd_n), .io_wr_n(io_wr_n),
        .xfer_done(xfer_done)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: phase number 0 idle, 1 waiting, 2 ack, 3 read, 4 write, 5 gap
    int m_ph = 0, m_addr = 0, m_cnt = 0;
    bit m_tc = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_addr = 0; m_cnt = 0; m_tc = 0;
        end else begin
            m_tc = 0;
            if (m_ph == 0) begin
                if (periph_req && m_cnt != 0) m_ph = 1;
                if (cfg_load) begin m_addr = cfg_addr; m_cnt = cfg_count; end
            end else if (m_ph == 1) begin
                if (hold_ack) m_ph = 2;
            end else if (m_ph == 2 || m_ph == 5) begin
                m_ph = 3;
            end else if (m_ph == 3) begin
                m_ph = 4;
            end else begin
                m_addr = (m_addr + 1) % AMOD;
                if (m_cnt == 1) begin m_ph = 0; m_tc = 1; end
                else m_ph = 5;
                m_cnt = m_cnt - 1;
            end
        end
    end

    int obs_addr[$];
    int tc_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            bit own, oe;
            own = (m_ph >= 2);
            oe  = own && hold_ack;
            chk("R2 hold_req", hold_req, m_ph != 0);
            chk("R3 periph_ack", periph_ack, own);
            chk("R9 bus_oe", bus_oe, oe);
            chk("R4 mem_rd_n", mem_rd_n, !(oe && (m_ph == 3 || m_ph == 4)));
            chk("R4 io_wr_n", io_wr_n, !(oe && m_ph == 4));
            chk("R5 bus_addr", bus_addr, oe ? m_addr : 0);
            chk("R7 xfer_done", xfer_done, m_tc);
            if (!io_wr_n) obs_addr.push_back(int'(bus_addr));
            if (xfer_done) tc_seen++;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic run_block(int start, int n, int grant_delay, bit mid_load);
        obs_addr.delete();
        tc_seen = 0;
        cfg_load = 1; cfg_addr = AW'(start); cfg_count = CW'(n);
        tick();
        cfg_load = 0; periph_req = 1;
        tick();
        periph_req = 0;
        chk("R2 hold raised after request", hold_req, 1);
        for (int i = 0; i < grant_delay; i++) begin
            tick();
            chk("R3 no ack before grant", periph_ack, 0);
        end
        hold_ack = 1;
        if (mid_load) begin
            tick(); tick(); tick();
            cfg_load = 1; cfg_addr = 8'h40; cfg_count = 4'd2;
            tick();
            cfg_load = 0;
        end
        for (int i = 0; i < 200 && hold_req; i++) tick();
        hold_ack = 0;
        tick(); tick();
        chk("R6 byte count", obs_addr.size(), n);
        for (int k = 0; k < obs_addr.size(); k++)
            chk("R5 address sequence", obs_addr[k], (start + k) % AMOD);
        chk("R7 one terminal pulse", tc_seen, 1);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1 reset values
        chk("R1 hold_req", hold_req, 0);
        chk("R1 periph_ack", periph_ack, 0);
        chk("R1 bus_oe", bus_oe, 0);
        chk("R1 mem_rd_n", mem_rd_n, 1);
        chk("R1 io_wr_n", io_wr_n, 1);
        chk("R1 xfer_done", xfer_done, 0);
        rst = 0;
        tick();
        // R8 request with the reset count of zero
        periph_req = 1;
        for (int i = 0; i < 4; i++) begin tick(); chk("R8 zero count after reset", hold_req, 0); end
        periph_req = 0;
        tick();
        run_block(8'h10, 3, 3, 0);
        // R8 finished block leaves count zero
        periph_req = 1;
        for (int i = 0; i < 4; i++) begin tick(); chk("R8 zero count after block", hold_req, 0); end
        periph_req = 0;
        tick();
        run_block(8'hFE, 4, 0, 1);   // R5 wrap, R10 mid-transfer reload ignored
        run_block(8'h80, 1, 1, 0);   // single byte
        run_block(8'hF5, 15, 2, 0);  // largest count, wraps too
        // R9 grant held high while idle drives nothing
        hold_ack = 1;
        tick();
        chk("R9 idle grant no drive", bus_oe, 0);
        hold_ack = 0;
        tick(); tick();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule